// File: doc/BRIEF.md
# Page-Programmed Parallel EEPROM Controller

This block is a synchronous model of the control logic inside a byte-wide parallel EEPROM that is written one page at a time. The system clock samples the three active-low bus strobes (chip enable, output enable, write enable). From them the block decodes two kinds of cycle: reads, and byte loads into a page buffer. Every strobe and bus signal is taken to be synchronous to the clock.

The buffer holds 64 bytes, each with its own flag. The first accepted load fixes the page. A load window, counted in clock cycles, restarts on every accepted load. When no further load arrives inside the window, the buffer closes and a programming phase begins. During that phase only the flagged bytes are written into the storage array. The array has 2K bytes by default and 8K bytes with `ADDR_W` = 13. While the programming phase runs, every read returns a polling byte, so the host can detect completion from data line 7.

Top module: `eeprom_page_ctl`

## Requirements
- R1: A read is sampled on a clock edge where `ce_n`=0, `oe_n`=0 and `we_n`=1. For every read, `dout_en` is 1 during the next cycle. In any cycle where `dout_en` is 0, `dout` is all zeros.
- R2: A byte load begins at the first edge where `ce_n`, `we_n` and `oe_n` read 0, 0 and 1. At that edge the address is captured, so the strobe that falls later sets it. The load completes at the first edge where that condition no longer holds, and `din` is captured at that edge, so the strobe that rises earlier sets the data.
- R3: Address bits [5:0] select the byte within a page. The bits above them select the page.
- R4: Each accepted load restarts a window of `LOAD_WIN` cycles. At the edge where the window runs out with no further accepted load, the block enters the programming phase, which lasts `PROG_CYC` cycles.
- R5: Bytes may be loaded in any order. A byte loaded twice keeps its last value. After programming, only the loaded bytes of the page hold new data, and every other byte keeps its previous contents.
- R6: A read sampled during the programming phase returns the last loaded byte with bit 7 inverted and bits 6..0 unchanged. Once the phase ends, reads return the stored data.
- R7: A load whose page differs from the page of the first load is discarded. It raises `page_err`, which stays at 1 until reset.
- R8: A load that completes during the programming phase has no effect on the array or on the polling byte.
- R9: `busy` rises in the cycle after the first load and falls when programming ends. After a single load it is high for `LOAD_WIN`+`PROG_CYC` cycles.
- R10: After reset, `busy`, `page_err` and `dout_en` are 0 and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Drive enable for the data outputs |
| busy | output | 1 | High from first load until programming completes |
| page_err | output | 1 | Sticky flag for a load outside the open page |

## Verification
The bench drives a strobe pair in which chip enable falls first and write enable falls with a new address. It then releases chip enable with one data value and write enable with another. A design that latched on the wrong edge would store the first address or the second data byte. Within one page, loads arrive out of order and one byte is loaded twice. A design that flushed the whole page or kept the first copy would then read back wrong neighbours or stale data. A later load is placed a few cycles before the window expires; a design whose timer did not restart would program early and lose that byte. Polling reads, a write to a foreign page and a write issued during programming exercise the inverted bit 7, the sticky error and the ignore rule. A behavioural reference model also follows `busy`, `page_err` and `dout` on every clock.

// File: rtl/pge_pkg.sv
package pge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pge_state_e;
endpackage

// File: rtl/pge_strobe.sv
// Decodes bus strobes: address at start of a write strobe, data at its end.
module pge_strobe #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          ld_fire,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          rd_req
);
  logic          wr_lvl;
  logic          wr_q;
  logic [AW-1:0] hold_q;

  assign wr_lvl = ~ce_n & ~we_n & oe_n;
  assign rd_req = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      wr_q <= wr_lvl;
      if (wr_lvl && !wr_q) hold_q <= addr;
    end
  end

  assign ld_fire = wr_q & ~wr_lvl;
  assign ld_addr = hold_q;
  assign ld_data = din;
endmodule

// File: rtl/pge_page_latch.sv
// Page buffer with one valid flag per byte slot.
module pge_page_latch #(
  parameter int DW     = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DW-1:0]    slot [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) slot[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we)    vld[wr_idx] <= 1'b1;
  end

  assign rd_data   = slot[rd_idx];
  assign rd_valid  = vld[rd_idx];
  assign any_valid = |vld;
endmodule

// File: rtl/pge_array.sv
// Storage array: one write port, one registered read port.
module pge_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eeprom_page_ctl.sv
module eeprom_page_ctl
  import pge_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 6,
  parameter int LOAD_WIN = 32,
  parameter int PROG_CYC = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int BLK_W  = ADDR_W - PAGE_W;
  localparam int WIN_W  = $clog2(LOAD_WIN + 1);
  localparam int PC_W   = $clog2(PROG_CYC + PAGE_N + 1);

  pge_state_e        st;
  logic [BLK_W-1:0]  page_q;
  logic [WIN_W-1:0]  win_cnt;
  logic [PC_W-1:0]   pcnt;
  logic [DATA_W-1:0] last_d;
  logic              err_q, en_q, poll_q;

  logic              ld_fire, rd_req;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic [DATA_W-1:0] slot_d, ram_q;
  logic              slot_vld, any_valid;

  pge_strobe #(.AW(ADDR_W), .DW(DATA_W)) u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .ld_fire(ld_fire), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_req(rd_req)
  );

  logic page_hit, accept, in_scan, mem_we, prog_done;
  logic [PAGE_W-1:0] prog_idx;

  assign page_hit  = (ld_addr[ADDR_W-1:PAGE_W] == page_q);
  assign accept    = ld_fire && ((st == ST_IDLE) || ((st == ST_LOAD) && page_hit));
  assign prog_idx  = pcnt[PAGE_W-1:0];
  assign in_scan   = (st == ST_PROG) && (pcnt < PC_W'(PAGE_N));
  assign mem_we    = in_scan && slot_vld;
  assign prog_done = (st == ST_PROG) && (pcnt == PC_W'(PROG_CYC - 1));

  pge_page_latch #(.DW(DATA_W), .PAGE_W(PAGE_W)) u_latch (
    .clk(clk), .rst(rst), .we(accept), .wr_idx(ld_addr[PAGE_W-1:0]),
    .wr_data(ld_data), .clr(prog_done), .rd_idx(prog_idx),
    .rd_data(slot_d), .rd_valid(slot_vld), .any_valid(any_valid)
  );

  pge_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr({page_q, prog_idx}), .wdata(slot_d),
    .raddr(addr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      page_q  <= '0;
      win_cnt <= '0;
      pcnt    <= '0;
      last_d  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept) last_d <= ld_data;
      unique case (st)
        ST_IDLE: if (accept) begin
          page_q  <= ld_addr[ADDR_W-1:PAGE_W];
          win_cnt <= '0;
          st      <= ST_LOAD;
        end
        ST_LOAD: begin
          if (ld_fire && !page_hit) err_q <= 1'b1;
          if (accept) win_cnt <= '0;
          else if (win_cnt == WIN_W'(LOAD_WIN - 1)) begin
            st   <= ST_PROG;
            pcnt <= '0;
          end else win_cnt <= win_cnt + 1'b1;
        end
        ST_PROG: begin
          if (prog_done) st <= ST_IDLE;
          else pcnt <= pcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      en_q   <= rd_req;
      poll_q <= rd_req && (st == ST_PROG);
    end
  end

  always_comb begin
    if (!en_q)       dout = '0;
    else if (poll_q) dout = {~last_d[DATA_W-1], last_d[DATA_W-2:0]};
    else             dout = ram_q;
  end

  assign dout_en  = en_q;
  assign busy     = (st != ST_IDLE);
  assign page_err = err_q;

  // R1
  rd_sample_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |-> $past(!ce_n && !oe_n && we_n));
  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD) |-> (win_cnt < WIN_W'(LOAD_WIN)));
  // R5
  flags_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> any_valid);
  // R5
  flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !any_valid);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R8
  prog_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && ld_fire && !prog_done) |=> (st == ST_PROG && $stable(last_d)));
  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ld_fire));
endmodule

// File: tb/sim_eeprom_page_ctl.sv
module sim_eeprom_page_ctl;
  localparam int AW = 11;
  localparam int LW = 32;
  localparam int PC = 96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, busy, page_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eeprom_page_ctl #(.ADDR_W(AW), .DATA_W(8), .PAGE_W(6), .LOAD_WIN(LW), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .busy(busy), .page_err(page_err)
  );

  // behavioural reference model
  logic [7:0] mem_m [int];
  logic [7:0] pend [int];
  int m_st, m_win, m_pc, m_page, m_hold, m_a;
  bit m_wq, m_err, m_en, m_poll, m_known, m_wl, m_rd, m_fire;
  logic [7:0] m_last, m_rv;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_win = 0; m_pc = 0; m_page = 0; m_hold = 0;
      m_wq = 0; m_err = 0; m_en = 0; m_poll = 0; m_last = 8'h00;
      pend.delete();
    end else begin
      m_wl = !ce_n && !we_n && oe_n;
      m_rd = !ce_n && !oe_n && we_n;
      m_fire = m_wq && !m_wl;
      m_a = int'(addr);
      m_en = m_rd;
      m_poll = m_rd && (m_st == 2);
      m_known = mem_m.exists(m_a);
      if (m_known) m_rv = mem_m[m_a];
      if (m_st == 0) begin
        if (m_fire) begin
          m_page = m_hold / 64; pend[m_hold] = din; m_last = din; m_win = 0; m_st = 1;
        end
      end else if (m_st == 1) begin
        if (m_fire && (m_hold / 64) == m_page) begin
          pend[m_hold] = din; m_last = din; m_win = 0;
        end else begin
          if (m_fire) m_err = 1;
          if (m_win == LW - 1) begin m_st = 2; m_pc = 0; end
          else m_win++;
        end
      end else begin
        if (m_pc == PC - 1) begin
          foreach (pend[k]) mem_m[k] = pend[k];
          pend.delete();
          m_st = 0;
        end else m_pc++;
      end
      if (m_wl && !m_wq) m_hold = m_a;
      m_wq = m_wl;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R1, R6, R7, R9)
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 model dout_en", int'(dout_en), int'(m_en));
      chk("R9 model busy", int'(busy), int'(m_st != 0));
      chk("R7 model page_err", int'(page_err), int'(m_err));
      if (!m_en) chk("R1 model idle dout", int'(dout), 0);
      else if (m_poll) chk("R6 model poll byte", int'(dout), int'({~m_last[7], m_last[6:0]}));
      else if (m_known) chk("R5 model read data", int'(dout), int'(m_rv));
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = AW'(a); din = d; oe_n = 1; ce_n = 0; we_n = 1;
    @(negedge clk); we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(input int a, output logic [7:0] d, output logic e);
    @(negedge clk); addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); d = dout; e = dout_en; ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  logic [7:0] rdv;
  logic rde;
  int n;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 page_err", int'(page_err), 0);
    chk("R10 dout_en", int'(dout_en), 0);
    chk("R10 dout", int'(dout), 0);

    // fill page 3 completely
    for (int i = 0; i < 64; i++) wr(3 * 64 + i, 8'(i) ^ 8'h5A);
    wait_idle();
    rd(3 * 64 + 0, rdv, rde);  chk("R3 page3 byte0", int'(rdv), 'h5A);
    rd(3 * 64 + 63, rdv, rde); chk("R3 page3 byte63", int'(rdv), 'h65);
    chk("R1 dout_en on read", int'(rde), 1);

    // R1: chip enable low but output enable high gives no drive
    @(negedge clk); addr = AW'(3 * 64); ce_n = 0; oe_n = 1; we_n = 1;
    @(negedge clk); chk("R1 no drive with oe high", int'(dout_en), 0);
    chk("R1 zero dout with oe high", int'(dout), 0);
    ce_n = 1;

    // partial page, out of order, with overwrite
    wr(3 * 64 + 5, 8'h11);
    wr(3 * 64 + 1, 8'h22);
    wr(3 * 64 + 5, 8'h33);
    wr(3 * 64 + 63, 8'h44);
    repeat (LW + 2) @(negedge clk);
    rd(3 * 64 + 63, rdv, rde);
    chk("R6 polling byte during programming", int'(rdv), 'hC4);
    // R8: strobe during programming is ignored
    wr(3 * 64 + 2, 8'h99);
    rd(3 * 64 + 63, rdv, rde);
    chk("R8 polling byte unchanged", int'(rdv), 'hC4);
    wait_idle();
    rd(3 * 64 + 63, rdv, rde); chk("R6 true data after completion", int'(rdv), 'h44);
    rd(3 * 64 + 5, rdv, rde);  chk("R5 overwritten byte keeps last", int'(rdv), 'h33);
    rd(3 * 64 + 1, rdv, rde);  chk("R5 out of order byte", int'(rdv), 'h22);
    rd(3 * 64 + 0, rdv, rde);  chk("R5 unloaded byte kept", int'(rdv), 'h5A);
    rd(3 * 64 + 2, rdv, rde);  chk("R8 ignored write left byte", int'(rdv), 'h58);

    // R2: address from later falling strobe, data from earlier rising strobe
    @(negedge clk); addr = AW'(7 * 64 + 3); oe_n = 1; ce_n = 0; we_n = 1;
    @(negedge clk); addr = AW'(7 * 64 + 10); we_n = 0;
    @(negedge clk); din = 8'h3C; ce_n = 1;
    @(negedge clk); din = 8'hC3; we_n = 1;
    wait_idle();
    rd(7 * 64 + 10, rdv, rde); chk("R2 captured address and data", int'(rdv), 'h3C);

    // R9: busy length after a single load
    wr(8 * 64, 8'h77);
    n = 1;
    while (busy) begin
      @(negedge clk);
      if (busy) n++;
    end
    chk("R9 busy cycles", n, LW + PC);
    repeat (2) @(negedge clk);

    // R4: a load just before expiry restarts the window
    wr(9 * 64 + 0, 8'h01);
    repeat (LW - 6) @(negedge clk);
    wr(9 * 64 + 1, 8'h02);
    wait_idle();
    rd(9 * 64 + 1, rdv, rde); chk("R4 late load kept", int'(rdv), 'h02);
    rd(9 * 64 + 0, rdv, rde); chk("R4 first load kept", int'(rdv), 'h01);

    // R7: load to a foreign page is dropped and flags an error
    wr(6 * 64, 8'h10);
    wait_idle();
    chk("R7 no error yet", int'(page_err), 0);
    wr(5 * 64, 8'hAB);
    wr(6 * 64, 8'hCD);
    chk("R7 error raised", int'(page_err), 1);
    wait_idle();
    chk("R7 error sticky", int'(page_err), 1);
    rd(5 * 64, rdv, rde); chk("R7 own page written", int'(rdv), 'hAB);
    rd(6 * 64, rdv, rde); chk("R7 foreign load discarded", int'(rdv), 'h10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule